// File: doc/BRIEF.md
# Banked GPIO Port Register Set

This block holds six 8-bit general-purpose I/O ports behind an indexed configuration register interface. The ports are grouped in pairs, and each pair belongs to one logical device. Software picks a logical device on `devSel`, puts a register number on `regIndex`, and either writes `regWdata` with a one-cycle `regWrite` strobe or reads `regRdata`, which follows index and device combinationally.

Every port has its own direction, data and polarity-inversion registers and an enable bit in its device's enable register. Two global registers are reached whatever device is selected. They hold one drive-mode bit per port, which picks push-pull or open-drain, and a pin-function field that must select GPIO before the first port's pins are driven. For each pin the block produces an output level and an output enable. Input pins pass through a two-stage synchroniser before they are read back. The sixth port has only five pins.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset every register reads 0, except the direction registers, which read all ones on implemented pins (0xFF, and 0x1F for the sixth port). All `pinOe` bits are 0.
- R2: Index 0x2C (global A) and index 0x29 (global B) are read and written whatever `devSel` holds. Other indices decode only when `devSel` is 0x09 (ports 1 and 2), 0x07 (ports 3 and 4) or 0x08 (ports 5 and 6). Unmapped accesses read 0 and their writes change nothing.
- R3: Inside a device, index 0x30 is the enable register. Indices 0xE0, 0xE1 and 0xE2 are direction, data and inversion for the device's first port, and 0xE4, 0xE5 and 0xE6 are the same for its second port. Each reads back what was written.
- R4: The enable bits are bits 0 and 1 of device 0x09 for ports 1 and 2, bits 0 and 1 of device 0x07 for ports 3 and 4, and bits 1 and 2 of device 0x08 for ports 5 and 6. A disabled port drives no pin, and its data register reads the stored value.
- R5: A direction bit of 1 makes the pin an input and 0 makes it an output. The level of an output pin is its data bit XOR its inversion bit. `pinOut` is 0 wherever `pinOe` is 0.
- R6: A set drive-mode bit selects push-pull, where an output pin drives its level with `pinOe`=1. The bits are global A bit 6 (port 1) and bit 7 (port 2), and global B bits 3, 4, 5 and 7 (ports 3 to 6).
- R7: In open-drain mode an output pin whose level is 0 drives 0 with `pinOe`=1, and one whose level is 1 has `pinOe`=0.
- R8: Port 1 drives its pins only while global A bits 1:0 equal 2.
- R9: On an enabled port, reading an input pin's data bit returns the synchronised pin level XOR its inversion bit. A pin change shows up in the read after the second rising clock edge.
- R10: Writes to the data bit of an input pin are stored and drive the pin once it is switched to output.
- R11: The sixth port has five pins. Bits 7:5 of its direction, data and inversion registers read 0, and pins 45 to 47 are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe |
| regIndex | input | 8 | Register number |
| devSel | input | 8 | Selected logical device number |
| regWdata | input | 8 | Write data |
| pinIn | input | 48 | Sampled pad levels, port p at bits 8p+7:8p |
| regRdata | output | 8 | Read data for the addressed register |
| pinOut | output | 48 | Output level per pin |
| pinOe | output | 48 | Output enable per pin |

## Verification
The bench goes after the places where an inversion or a gating term is easy to drop. A disabled port with input pins must read its stored byte; a design that ignores the enable would return the synchronised pins instead. Open-drain pins at level 1 must release; a design that treats open-drain like push-pull would drive them high. A pin change is sampled after exactly one edge and again after two, so a synchroniser that is too short or too long shows up. Other checks cover data written while a pin is an input, which a careless design would drop or drive at once, the gating of port 1 by its function field, the five-pin port's tie-offs, and writes through an unmapped device number, each against a bench model under random traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_DEV = 3;
  localparam int NUM_PORTS = 2 * NUM_DEV;

  localparam logic [7:0] IDX_GLB_A = 8'h2C;
  localparam logic [7:0] IDX_GLB_B = 8'h29;
  localparam logic [7:0] IDX_ENABLE = 8'h30;
  localparam logic [4:0] IDX_PORT_HI = 5'b11100;
  localparam logic [1:0] FUNC_GPIO = 2'd2;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_GLB_A, FLD_GLB_B, FLD_ENABLE, FLD_DIR, FLD_DATA, FLD_INV
  } regField_e;

  // strobes and selects handed from control to datapath
  typedef struct packed {
    logic      wr;
    regField_e field;
    logic [1:0] dev;
    logic [2:0] port;
  } regSel_t;

  function automatic int enableBitOf(int p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 0;
      3: return 1;
      4: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int driveBitOf(int p);
    case (p)
      0: return 6;
      1: return 7;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] DEV_LO  = 8'h09,
  parameter logic [7:0] DEV_MID = 8'h07,
  parameter logic [7:0] DEV_HI  = 8'h08
) (
  input  logic       regWrite,
  input  logic [7:0] regIndex,
  input  logic [7:0] devSel,
  output regSel_t    sel
);
  logic       devHit;
  logic [1:0] devNum;

  always_comb begin
    devHit = 1'b1;
    devNum = 2'd0;
    if (devSel == DEV_LO) devNum = 2'd0;
    else if (devSel == DEV_MID) devNum = 2'd1;
    else if (devSel == DEV_HI) devNum = 2'd2;
    else devHit = 1'b0;
  end

  always_comb begin
    sel       = '0;
    sel.field = FLD_NONE;
    sel.dev   = devNum;
    sel.port  = {devNum, regIndex[2]};
    if (regIndex == IDX_GLB_A) begin
      sel.field = FLD_GLB_A;
    end else if (regIndex == IDX_GLB_B) begin
      sel.field = FLD_GLB_B;
    end else if (devHit) begin
      if (regIndex == IDX_ENABLE) begin
        sel.field = FLD_ENABLE;
      end else if (regIndex[7:3] == IDX_PORT_HI) begin
        case (regIndex[1:0])
          2'd0: sel.field = FLD_DIR;
          2'd1: sel.field = FLD_DATA;
          2'd2: sel.field = FLD_INV;
          default: sel.field = FLD_NONE;
        endcase
      end
    end
    sel.wr = regWrite && (sel.field != FLD_NONE);
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int LAST_PORT_PINS = 5,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regSel_t           sel,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  logic [PORT_W-1:0] glbA, glbB;
  logic [PORT_W-1:0] enReg   [NUM_DEV];
  logic [PORT_W-1:0] viewData[NUM_PORTS];
  logic [PORT_W-1:0] dirQ    [NUM_PORTS];
  logic [PORT_W-1:0] invQ    [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glbA <= '0;
      glbB <= '0;
      for (int d = 0; d < NUM_DEV; d++) enReg[d] <= '0;
    end else if (sel.wr) begin
      case (sel.field)
        FLD_GLB_A:  glbA <= wrData;
        FLD_GLB_B:  glbB <= wrData;
        FLD_ENABLE: enReg[sel.dev] <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int W = (p == NUM_PORTS - 1) ? LAST_PORT_PINS : PORT_W;
    localparam logic [PORT_W-1:0] MASK = PORT_W'((64'd1 << W) - 64'd1);
    localparam int EN_BIT = enableBitOf(p);
    localparam int DRV_BIT = driveBitOf(p);

    logic [PORT_W-1:0] dirR, dataR, invR, level, oeV, relMask;
    logic [PORT_W-1:0] syncR [SYNC_STAGES];
    logic portHit, portOn, pushPull;

    assign portHit = sel.wr && (sel.port == 3'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirR  <= MASK;
        dataR <= '0;
        invR  <= '0;
        for (int s = 0; s < SYNC_STAGES; s++) syncR[s] <= '0;
      end else begin
        if (portHit && sel.field == FLD_DIR)  dirR  <= wrData & MASK;
        if (portHit && sel.field == FLD_DATA) dataR <= wrData & MASK;
        if (portHit && sel.field == FLD_INV)  invR  <= wrData & MASK;
        syncR[0] <= pinIn[p*PORT_W +: PORT_W] & MASK;
        for (int s = 1; s < SYNC_STAGES; s++) syncR[s] <= syncR[s-1];
      end
    end

    if (p == 0) begin : g_func
      assign portOn = enReg[p/2][EN_BIT] && (glbA[1:0] == FUNC_GPIO);
    end else begin : g_nofunc
      assign portOn = enReg[p/2][EN_BIT];
    end

    if (p < 2) begin : g_drvA
      assign pushPull = glbA[DRV_BIT];
    end else begin : g_drvB
      assign pushPull = glbB[DRV_BIT];
    end

    assign level   = dataR ^ invR;
    assign relMask = pushPull ? {PORT_W{1'b1}} : ~level;
    assign oeV     = {PORT_W{portOn}} & ~dirR & relMask & MASK;

    assign pinOe[p*PORT_W +: PORT_W]  = oeV;
    assign pinOut[p*PORT_W +: PORT_W] = oeV & level;

    assign viewData[p] = portOn ?
        ((dirR & (syncR[SYNC_STAGES-1] ^ invR)) | (~dirR & dataR)) : dataR;
    assign dirQ[p] = dirR;
    assign invQ[p] = invR;
  end

  always_comb begin
    case (sel.field)
      FLD_GLB_A:  rdData = glbA;
      FLD_GLB_B:  rdData = glbB;
      FLD_ENABLE: rdData = enReg[sel.dev];
      FLD_DIR:    rdData = dirQ[sel.port];
      FLD_DATA:   rdData = viewData[sel.port];
      FLD_INV:    rdData = invQ[sel.port];
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] DEV_LO  = 8'h09,
  parameter logic [7:0] DEV_MID = 8'h07,
  parameter logic [7:0] DEV_HI  = 8'h08,
  parameter int PORT_W = 8,
  parameter int LAST_PORT_PINS = 5,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrite,
  input  logic [7:0]        regIndex,
  input  logic [7:0]        devSel,
  input  logic [PORT_W-1:0] regWdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PORT_W-1:0] regRdata,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  regSel_t sel;

  gpio_bank_ctrl #(
    .DEV_LO(DEV_LO), .DEV_MID(DEV_MID), .DEV_HI(DEV_HI)
  ) u_ctrl (
    .regWrite(regWrite), .regIndex(regIndex), .devSel(devSel), .sel(sel)
  );

  gpio_bank_dp #(
    .PORT_W(PORT_W), .LAST_PORT_PINS(LAST_PORT_PINS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wrData(regWdata), .pinIn(pinIn),
    .rdData(regRdata), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter logic [7:0] DEV_LO  = 8'h09,
  parameter logic [7:0] DEV_MID = 8'h07,
  parameter int PORT_W = 8,
  parameter int LAST_PORT_PINS = 5,
  parameter int PIN_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrite,
  input logic [7:0]        regIndex,
  input logic [7:0]        devSel,
  input logic [PORT_W-1:0] regWdata,
  input logic [PORT_W-1:0] regRdata,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOe
);
  localparam int TAIL = PORT_W - LAST_PORT_PINS;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pinOe == '0);

  assert_tail_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOe >> (PIN_W - TAIL)) == '0) && ((pinOut >> (PIN_W - TAIL)) == '0));

  assert_input_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrite && devSel == DEV_LO && regIndex == 8'hE0 && regWdata == '1)
    |=> pinOe[PORT_W-1:0] == '0);

  assert_disable_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrite && devSel == DEV_LO && regIndex == 8'h30 && regWdata == '0)
    |=> pinOe[2*PORT_W-1:0] == '0);

  assert_func_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrite && regIndex == 8'h2C && regWdata[1:0] != 2'd2)
    |=> pinOe[PORT_W-1:0] == '0);

  assert_inv_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrite && devSel == DEV_MID && regIndex == 8'hE2)
    |=> (!($stable(regIndex) && $stable(devSel)) || regRdata == $past(regWdata)));
endmodule

bind gpio_bank_top gpio_bank_chk #(
  .DEV_LO(DEV_LO), .DEV_MID(DEV_MID), .PORT_W(PORT_W),
  .LAST_PORT_PINS(LAST_PORT_PINS), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrite(regWrite), .regIndex(regIndex),
  .devSel(devSel), .regWdata(regWdata), .regRdata(regRdata),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIN_W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrite = 1'b0;
  logic [7:0] regIndex = '0, devSel = '0, regWdata = '0;
  logic [PIN_W-1:0] pinIn = '0;
  logic [7:0] regRdata;
  logic [PIN_W-1:0] pinOut, pinOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_top dut_i (
    .clk(clk), .rst_n(rst_n), .regWrite(regWrite), .regIndex(regIndex),
    .devSel(devSel), .regWdata(regWdata), .pinIn(pinIn),
    .regRdata(regRdata), .pinOut(pinOut), .pinOe(pinOe)
  );

  // bench model of the register state
  logic [7:0] mA, mB;
  logic [7:0] mEn [3];
  logic [7:0] mDir [6];
  logic [7:0] mData [6];
  logic [7:0] mInv [6];

  function automatic int devOf(logic [7:0] d);
    if (d == 8'h09) return 0;
    if (d == 8'h07) return 1;
    if (d == 8'h08) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] maskOf(int p);
    return (p == 5) ? 8'h1F : 8'hFF;
  endfunction

  function automatic int enBit(int p);
    int t[6] = '{0, 1, 0, 1, 1, 2};
    return t[p];
  endfunction

  function automatic int drvBit(int p);
    int t[6] = '{6, 7, 3, 4, 5, 7};
    return t[p];
  endfunction

  function automatic bit active(int p);
    return mEn[p/2][enBit(p)] && (p != 0 || mA[1:0] == 2'd2);
  endfunction

  function automatic bit pushPull(int p);
    return (p < 2) ? mA[drvBit(p)] : mB[drvBit(p)];
  endfunction

  function automatic int portOf(logic [7:0] d, logic [7:0] i);
    int dv = devOf(d);
    if (dv < 0 || i == 8'h2C || i == 8'h29) return -1;
    if (i[7:3] != 5'b11100 || i[1:0] == 2'd3) return -1;
    return dv * 2 + int'(i[2]);
  endfunction

  task automatic modelReset();
    mA = '0; mB = '0;
    for (int d = 0; d < 3; d++) mEn[d] = '0;
    for (int p = 0; p < 6; p++) begin
      mDir[p] = maskOf(p); mData[p] = '0; mInv[p] = '0;
    end
  endtask

  task automatic modelWrite(logic [7:0] d, logic [7:0] i, logic [7:0] w);
    int p = portOf(d, i);
    if (i == 8'h2C) mA = w;
    else if (i == 8'h29) mB = w;
    else if (devOf(d) >= 0 && i == 8'h30) mEn[devOf(d)] = w;
    else if (p >= 0) begin
      case (i[1:0])
        2'd0: mDir[p] = w & maskOf(p);
        2'd1: mData[p] = w & maskOf(p);
        default: mInv[p] = w & maskOf(p);
      endcase
    end
  endtask

  function automatic logic [7:0] expRead(logic [7:0] d, logic [7:0] i);
    int p = portOf(d, i);
    logic [7:0] pins;
    if (i == 8'h2C) return mA;
    if (i == 8'h29) return mB;
    if (devOf(d) >= 0 && i == 8'h30) return mEn[devOf(d)];
    if (p < 0) return 8'h00;
    case (i[1:0])
      2'd0: return mDir[p];
      2'd2: return mInv[p];
      default: begin
        if (!active(p)) return mData[p];
        pins = pinIn[p*8 +: 8] & maskOf(p);
        return (mDir[p] & (pins ^ mInv[p])) | (~mDir[p] & mData[p]);
      end
    endcase
  endfunction

  task automatic expPins(output logic [PIN_W-1:0] eOe, output logic [PIN_W-1:0] eOut);
    eOe = '0; eOut = '0;
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < 8; b++) begin
        if (maskOf(p)[b] && active(p) && !mDir[p][b]) begin
          logic lvl;
          lvl = mData[p][b] ^ mInv[p][b];
          eOe[p*8+b] = pushPull(p) || !lvl;
          eOut[p*8+b] = eOe[p*8+b] && lvl;
        end
      end
    end
  endtask

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, logic [7:0] i, logic [7:0] w);
    @(negedge clk);
    regWrite = 1'b1; devSel = d; regIndex = i; regWdata = w;
    @(negedge clk);
    regWrite = 1'b0;
    modelWrite(d, i, w);
  endtask

  task automatic rd(logic [7:0] d, logic [7:0] i, output logic [7:0] v);
    regWrite = 1'b0; devSel = d; regIndex = i;
    #1 v = regRdata;
  endtask

  task automatic checkRead(logic [7:0] d, logic [7:0] i, string tag);
    logic [7:0] v, e;
    rd(d, i, v);
    e = expRead(d, i);
    check(v == e, tag, 64'(v), 64'(e));
  endtask

  task automatic checkPins(string tag);
    logic [PIN_W-1:0] eOe, eOut;
    expPins(eOe, eOut);
    check(pinOe == eOe && pinOut == eOut, tag, {pinOe[31:0], pinOut[31:0]}, {eOe[31:0], eOut[31:0]});
  endtask

  task automatic setPins(logic [PIN_W-1:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [7:0] IDX_LIST [11] = '{8'h2C, 8'h29, 8'h30, 8'hE0, 8'hE1,
                                           8'hE2, 8'hE4, 8'hE5, 8'hE6, 8'hE3, 8'h10};
  localparam logic [7:0] DEV_LIST [4] = '{8'h09, 8'h07, 8'h08, 8'h05};

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pinOe == '0, "R1 pinOe after reset", 64'(pinOe), 64'd0);
    rd(8'h09, 8'hE0, v); check(v == 8'hFF, "R1 port1 direction", 64'(v), 64'hFF);
    rd(8'h08, 8'hE4, v); check(v == 8'h1F, "R1 R11 port6 direction", 64'(v), 64'h1F);
    rd(8'h07, 8'h30, v); check(v == 8'h00, "R1 enable register", 64'(v), 64'h00);

    // R2 global access under any device, unmapped device ignored
    wr(8'h55, 8'h29, 8'h3C);
    rd(8'h09, 8'h29, v); check(v == 8'h3C, "R2 global B via other device", 64'(v), 64'h3C);
    wr(8'h05, 8'hE0, 8'h00);
    rd(8'h09, 8'hE0, v); check(v == 8'hFF, "R2 unmapped write ignored", 64'(v), 64'hFF);
    rd(8'h05, 8'hE0, v); check(v == 8'h00, "R2 unmapped read zero", 64'(v), 64'h00);

    // R3 R4 R5 R6 port 3 push-pull
    wr(8'h07, 8'h30, 8'h01);
    wr(8'h00, 8'h29, 8'h08);
    wr(8'h07, 8'hE0, 8'h00);
    wr(8'h07, 8'hE1, 8'hA5);
    wr(8'h07, 8'hE2, 8'h0F);
    check(pinOe[23:16] == 8'hFF && pinOut[23:16] == 8'hAA, "R5 R6 push-pull level",
          {pinOe[23:16], pinOut[23:16]}, 64'hFFAA);
    rd(8'h07, 8'hE2, v); check(v == 8'h0F, "R3 inversion readback", 64'(v), 64'h0F);

    // R7 open drain
    wr(8'h00, 8'h29, 8'h00);
    check(pinOe[23:16] == 8'h55 && pinOut[23:16] == 8'h00, "R7 open-drain",
          {pinOe[23:16], pinOut[23:16]}, 64'h5500);

    // R4 disabled port
    wr(8'h07, 8'h30, 8'h02);
    wr(8'h07, 8'hE0, 8'hF0);
    setPins(48'h00_00_00_FF_00_00);
    check(pinOe[23:16] == 8'h00, "R4 disabled port drives nothing", 64'(pinOe[23:16]), 64'h0);
    rd(8'h07, 8'hE1, v); check(v == 8'hA5, "R4 disabled data readback", 64'(v), 64'hA5);
    setPins('0);

    // R8 port 1 function field
    wr(8'h09, 8'h30, 8'h03);
    wr(8'h09, 8'hE0, 8'h00);
    wr(8'h09, 8'hE1, 8'hFF);
    wr(8'h00, 8'h2C, 8'h40);
    check(pinOe[7:0] == 8'h00, "R8 function not GPIO", 64'(pinOe[7:0]), 64'h0);
    wr(8'h00, 8'h2C, 8'h42);
    check(pinOe[7:0] == 8'hFF && pinOut[7:0] == 8'hFF, "R8 function GPIO",
          {pinOe[7:0], pinOut[7:0]}, 64'hFFFF);

    // R9 synchroniser latency on port 2
    wr(8'h09, 8'hE6, 8'h01);
    @(negedge clk);
    pinIn[15:8] = 8'h3C;
    @(negedge clk);
    rd(8'h09, 8'hE5, v); check(v == 8'h01, "R9 one edge after change", 64'(v), 64'h01);
    @(negedge clk);
    rd(8'h09, 8'hE5, v); check(v == 8'h3D, "R9 two edges after change", 64'(v), 64'h3D);

    // R10 data written to input pins
    wr(8'h09, 8'hE5, 8'h81);
    check(pinOe[15:8] == 8'h00, "R10 input not driven", 64'(pinOe[15:8]), 64'h0);
    rd(8'h09, 8'hE5, v); check(v == 8'h3D, "R10 input reads pins", 64'(v), 64'h3D);
    wr(8'h00, 8'h2C, 8'hC2);
    wr(8'h09, 8'hE4, 8'h00);
    check(pinOe[15:8] == 8'hFF && pinOut[15:8] == 8'h80, "R10 stored data drives",
          {pinOe[15:8], pinOut[15:8]}, 64'hFF80);
    rd(8'h09, 8'hE5, v); check(v == 8'h81, "R10 stored data readback", 64'(v), 64'h81);

    // R11 five-pin port
    wr(8'h08, 8'hE5, 8'hFF);
    rd(8'h08, 8'hE5, v); check(v == 8'h1F, "R11 data upper bits", 64'(v), 64'h1F);
    wr(8'h08, 8'h30, 8'h04);
    wr(8'h08, 8'hE4, 8'h00);
    wr(8'h00, 8'h29, 8'h80);
    check(pinOe[47:40] == 8'h1F && pinOut[47:40] == 8'h1F, "R11 five pins driven",
          {pinOe[47:40], pinOut[47:40]}, 64'h1F1F);

    // random traffic against the model: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 8) begin
        wr(DEV_LIST[$urandom % 4], IDX_LIST[$urandom % 11], 8'($urandom));
      end else if (r == 8) begin
        setPins({16'($urandom), 32'($urandom)});
      end else begin
        @(negedge clk);
      end
      checkPins("R5 R6 R7 R8 R11 random pins");
      checkRead(DEV_LIST[$urandom % 4], IDX_LIST[$urandom % 11], "R2 R3 R4 R9 random read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule